// File: doc/BRIEF.md
# Serial Clock Divider with Selectable Granularity

This block produces the serial clock for one channel of a serial peripheral master. It runs entirely on a single core clock `clk` with clock enables and generates no gated or derived clock. The core clock runs at twice the reference rate (for example, 96 MHz for a 48 MHz reference). One half-period of the serial clock is therefore D core cycles, and one full serial clock period is D reference periods. With D = 1 the serial clock toggles on every core cycle, so it runs continuously at the reference rate.

A mode bit selects how the divider D is formed:

- **Coarse mode:** D is a power of two, 2^k, where k comes from a 4-bit field.
- **Fine mode:** D is any integer N+1. The low 4 bits of N come from the same 4-bit field and the high 8 bits come from an 8-bit extension field. The largest fine divider is 4096.

The polarity bit sets the idle level. The phase bit selects whether data is sampled on the leading or trailing edge. All five configuration inputs are captured only while the channel is disabled.

A three-state machine drives the serial clock level:

| State | Meaning |
|---|---|
| `ST_IDLE` | Channel disabled; the serial clock sits at its idle level. |
| `ST_LOW` | Enabled; the serial clock is at its idle level. |
| `ST_HIGH` | Enabled; the serial clock is at its active level. |

Its transitions are:

- **Enable:** `ST_IDLE` → `ST_LOW`, or `ST_IDLE` → `ST_HIGH` when D = 1.
- **Leading edge:** `ST_LOW` → `ST_HIGH`, taken when the half-period counter reaches D−1.
- **Trailing edge:** `ST_HIGH` → `ST_LOW`, taken on the same counter condition.
- **Disable:** any state → `ST_IDLE` whenever the enable input is low.

Top module: `sclk_divgen`

## Requirements
- R1: In coarse mode (`fine_sel`=0), successive serial clock transitions are 2^`clkd_fld` core cycles apart, for `clkd_fld` from 0 to 15.
- R2: In fine mode (`fine_sel`=1), successive transitions are N+1 core cycles apart, where N = {`ext_fld`,`clkd_fld`} (the extension field forms bits 11..4), so dividers from 1 to 4096 are reachable.
- R3: With a divider of 1, `sclk_o` changes level on every core cycle while enabled, and `tgl_stb_o` stays high.
- R4: The mode, both divider fields, polarity and phase are loaded on every clock edge where `chan_en` is low. Changes to these inputs while `chan_en` is high have no effect on timing or levels.
- R5: While the channel is disabled, `sclk_o` equals the captured polarity. Dropping `chan_en` returns `sclk_o` to that idle level one core cycle later, with no strobe.
- R6: The half-period counter restarts from zero on every enable. The first transition after `chan_en` rises comes exactly D core cycles later.
- R7: `tgl_stb_o` is high for exactly the cycles in which `sclk_o` has just taken a new level because of a divider expiry.
- R8: `smp_stb_o` marks the sampling edges. With `cpha`=0 it accompanies leading edges (idle→active); with `cpha`=1 it accompanies trailing edges. It is never high without `tgl_stb_o`.
- R9: During reset, both strobes are low and `sclk_o` is low (the reset polarity is 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, twice the reference rate |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_en | input | 1 | Channel enable; configuration is captured while low |
| fine_sel | input | 1 | 0 = power-of-two divider, 1 = integer divider |
| clkd_fld | input | 4 | Coarse exponent, or low bits of N in fine mode |
| ext_fld | input | 8 | High bits of N in fine mode |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | 0 = sample on leading edge, 1 = sample on trailing edge |
| sclk_o | output | 1 | Serial clock level with polarity applied |
| tgl_stb_o | output | 1 | One-cycle strobe in each cycle after a serial clock transition |
| smp_stb_o | output | 1 | Subset of `tgl_stb_o` marking sampling edges |

## Verification
The assertions assume the following about the inputs:

- `chan_en` and the configuration inputs are synchronous to `clk`.
- The captured configuration is the only state that can change the divider. This is why the frozen-configuration and toggle-alternation properties rely on no reload having happened in the preceding enabled cycle.

The stimulus respects these assumptions. It changes every input only on the falling edge of `clk`. It always leaves at least one disabled rising edge between writing new fields and raising the enable. It moves fields while enabled only in the test that exercises R4.

// File: rtl/sclk_divgen_pkg.sv
`timescale 1ns/1ps
package sclk_divgen_pkg;

    // Serial clock level state
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } sclk_state_e;

endpackage

// File: rtl/sclk_cfg_latch.sv
`timescale 1ns/1ps
module sclk_cfg_latch #(
    parameter int COARSE_W = 4,
    parameter int EXT_W    = 8,
    parameter int DIV_W    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                chan_en,
    input  logic                fine_sel,
    input  logic [COARSE_W-1:0] clkd_fld,
    input  logic [EXT_W-1:0]    ext_fld,
    input  logic                cpol,
    input  logic                cpha,
    output logic [DIV_W-1:0]    term_o,
    output logic                cpol_o,
    output logic                cpha_o
);

    localparam int FINE_W = COARSE_W + EXT_W;

    logic                fine_q;
    logic [COARSE_W-1:0] clkd_q;
    logic [EXT_W-1:0]    ext_q;
    logic                cpol_q;
    logic                cpha_q;
    logic [DIV_W-1:0]    pow_w;
    logic [DIV_W-1:0]    fine_w;

    // Capture the channel setup only while the channel is off
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fine_q <= 1'b0;
            clkd_q <= '0;
            ext_q  <= '0;
            cpol_q <= 1'b0;
            cpha_q <= 1'b0;
        end else if (!chan_en) begin
            fine_q <= fine_sel;
            clkd_q <= clkd_fld;
            ext_q  <= ext_fld;
            cpol_q <= cpol;
            cpha_q <= cpha;
        end
    end

    // Terminal count = divider minus one
    always_comb begin
        pow_w  = {{(DIV_W-1){1'b0}}, 1'b1} << clkd_q;
        fine_w = DIV_W'({ext_q, clkd_q});
        term_o = fine_q ? fine_w : (pow_w - DIV_W'(1));
    end

    assign cpol_o = cpol_q;
    assign cpha_o = cpha_q;

    // R4: nothing captured moves across an enabled edge
    assert_cfg_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(chan_en) |-> ($stable(term_o) && $stable(cpol_o) && $stable(cpha_o)))
        else $error("captured configuration changed while enabled");

    initial begin
        if (FINE_W >= DIV_W) $error("DIV_W too narrow for fine divider");
    end

endmodule

// File: rtl/sclk_half_cnt.sv
`timescale 1ns/1ps
module sclk_half_cnt #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] term_i,
    output logic             hit_o
);

    logic [DIV_W-1:0] cnt_q;

    assign hit_o = run && (cnt_q == term_i);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || hit_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

    // R6: counter stays inside the half period
    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= term_i))
        else $error("half-period counter beyond terminal");

    // R6: disabling clears the count so a new enable starts from zero
    assert_cnt_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0))
        else $error("counter not cleared while disabled");

    // R6: counting advances by one between expiries
    assert_cnt_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !$past(hit_o)) |-> (cnt_q == $past(cnt_q) + DIV_W'(1)))
        else $error("counter skipped a step");

endmodule

// File: rtl/sclk_edge_fsm.sv
`timescale 1ns/1ps
module sclk_edge_fsm
    import sclk_divgen_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic hit,
    input  logic cpol,
    input  logic cpha,
    output logic sclk_o,
    output logic tgl_o,
    output logic smp_o
);

    sclk_state_e state_q;
    sclk_state_e state_d;
    logic        tgl_q;
    logic        smp_q;
    logic        going_active;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!run) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = hit ? ST_HIGH : ST_LOW;
                ST_LOW:  state_d = hit ? ST_HIGH : ST_LOW;
                ST_HIGH: state_d = hit ? ST_LOW  : ST_HIGH;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    assign going_active = (state_q != ST_HIGH);

    // Registered strobes aligned with the new level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgl_q <= 1'b0;
            smp_q <= 1'b0;
        end else begin
            tgl_q <= run && hit;
            smp_q <= run && hit && (going_active ^ cpha);
        end
    end

    assign sclk_o = cpol ^ (state_q == ST_HIGH);
    assign tgl_o  = tgl_q;
    assign smp_o  = smp_q;

    // R7: every strobe comes with a level change
    assert_tgl_moves_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tgl_o |-> (sclk_o != $past(sclk_o)))
        else $error("toggle strobe without a level change");

    // R8: sampling marks are a subset of transitions
    assert_smp_subset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        smp_o |-> tgl_o)
        else $error("sample strobe without a transition");

    // R7: level moves only when the strobe says so
    assert_level_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && run && !tgl_o) |-> $stable(sclk_o))
        else $error("serial clock moved without a strobe");

endmodule

// File: rtl/sclk_divgen.sv
`timescale 1ns/1ps
module sclk_divgen #(
    parameter int COARSE_W = 4,
    parameter int EXT_W    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                chan_en,
    input  logic                fine_sel,
    input  logic [COARSE_W-1:0] clkd_fld,
    input  logic [EXT_W-1:0]    ext_fld,
    input  logic                cpol,
    input  logic                cpha,
    output logic                sclk_o,
    output logic                tgl_stb_o,
    output logic                smp_stb_o
);

    localparam int POW_MAX = (1 << COARSE_W) - 1;
    localparam int FINE_W  = COARSE_W + EXT_W;
    localparam int DIV_W   = (POW_MAX + 1 > FINE_W + 1) ? POW_MAX + 1 : FINE_W + 1;

    logic [DIV_W-1:0] term_w;
    logic             cpol_w;
    logic             cpha_w;
    logic             hit_w;

    sclk_cfg_latch #(
        .COARSE_W (COARSE_W),
        .EXT_W    (EXT_W),
        .DIV_W    (DIV_W)
    ) cfg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .chan_en  (chan_en),
        .fine_sel (fine_sel),
        .clkd_fld (clkd_fld),
        .ext_fld  (ext_fld),
        .cpol     (cpol),
        .cpha     (cpha),
        .term_o   (term_w),
        .cpol_o   (cpol_w),
        .cpha_o   (cpha_w)
    );

    sclk_half_cnt #(
        .DIV_W (DIV_W)
    ) cnt_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (chan_en),
        .term_i (term_w),
        .hit_o  (hit_w)
    );

    sclk_edge_fsm fsm_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (chan_en),
        .hit    (hit_w),
        .cpol   (cpol_w),
        .cpha   (cpha_w),
        .sclk_o (sclk_o),
        .tgl_o  (tgl_stb_o),
        .smp_o  (smp_stb_o)
    );

    // R5: one cycle after a disabled edge the level is idle
    assert_idle_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |=> (sclk_o == cpol_w && !tgl_stb_o))
        else $error("serial clock not idle after disable");

    // R3: divider of one toggles every enabled cycle
    assert_div1_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(chan_en) && $past(term_w) == '0) |-> tgl_stb_o)
        else $error("divide-by-one missed a transition");

    // R9: strobes quiet in reset
    assert_reset_quiet_R9: assert property (@(posedge clk)
        $past(!rst_n) |-> (!tgl_stb_o && !smp_stb_o))
        else $error("strobe active out of reset");

endmodule

// File: tb/sclk_divgen_tb_top.sv
`timescale 1ns/1ps
module sclk_divgen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chan_en = 1'b0;
    logic       fine_sel = 1'b0;
    logic [3:0] clkd_fld = '0;
    logic [7:0] ext_fld = '0;
    logic       cpol = 1'b0;
    logic       cpha = 1'b0;
    logic       sclk_o;
    logic       tgl_stb_o;
    logic       smp_stb_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sclk_divgen dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .chan_en   (chan_en),
        .fine_sel  (fine_sel),
        .clkd_fld  (clkd_fld),
        .ext_fld   (ext_fld),
        .cpol      (cpol),
        .cpha      (cpha),
        .sclk_o    (sclk_o),
        .tgl_stb_o (tgl_stb_o),
        .smp_stb_o (smp_stb_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Configure while disabled, enable, record the first two transitions
    task automatic measure(input bit fine, input logic [3:0] c, input logic [7:0] e,
                           input bit pol, input bit pha, input int dv, input string req);
        int t1 = 0;
        int t2 = 0;
        int nt = 0;
        bit s1 = 0, s2 = 0, m1 = 0, m2 = 0;
        @(negedge clk);
        chan_en = 1'b0; fine_sel = fine; clkd_fld = c; ext_fld = e; cpol = pol; cpha = pha;
        @(negedge clk);
        check({req, " R5 idle level"}, sclk_o, pol);
        chan_en = 1'b1;
        for (int n = 1; n <= 2 * dv; n++) begin
            step();
            if (tgl_stb_o) begin
                nt++;
                if (nt == 1) begin t1 = n; s1 = sclk_o; m1 = smp_stb_o; end
                else if (nt == 2) begin t2 = n; s2 = sclk_o; m2 = smp_stb_o; end
            end
        end
        check({req, " transition count"}, nt, 2);
        check({req, " R6 first transition"}, t1, dv);
        check({req, " half period"}, t2 - t1, dv);
        check({req, " leading level"}, s1, !pol);
        check({req, " trailing level"}, s2, pol);
        check({req, " R8 leading sample"}, m1, !pha);
        check({req, " R8 trailing sample"}, m2, pha);
        @(negedge clk);
        chan_en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        int mm;
        int mask;
        // R9 reset state
        repeat (3) @(negedge clk);
        check("R9 tgl in reset", tgl_stb_o, 0);
        check("R9 smp in reset", smp_stb_o, 0);
        check("R9 sclk in reset", sclk_o, 0);
        rst_n = 1'b1;
        cpol = 1'b1;
        step();
        check("R5 idle follows polarity", sclk_o, 1);

        // R1 coarse sweep
        for (int c = 0; c < 16; c++) begin
            measure(1'b0, 4'(c), 8'h00, c[0], c[1], 1 << c, $sformatf("R1 clkd=%0d", c));
        end

        // R2 fine sweep
        measure(1'b1, 4'h0, 8'h00, 1'b0, 1'b0, 1,    "R2 div1");
        measure(1'b1, 4'h1, 8'h00, 1'b1, 1'b0, 2,    "R2 div2");
        measure(1'b1, 4'h2, 8'h00, 1'b0, 1'b1, 3,    "R2 div3");
        measure(1'b1, 4'h0, 8'h01, 1'b1, 1'b1, 17,   "R2 div17");
        measure(1'b1, 4'hE, 8'h0F, 1'b0, 1'b0, 255,  "R2 div255");
        measure(1'b1, 4'hF, 8'hFF, 1'b1, 1'b0, 4096, "R2 div4096");

        // R3 continuous toggling at divider one
        @(negedge clk);
        fine_sel = 1'b1; clkd_fld = 4'h0; ext_fld = 8'h00; cpol = 1'b0; cpha = 1'b0;
        @(negedge clk);
        chan_en = 1'b1;
        mm = 0;
        for (int n = 1; n <= 12; n++) begin
            step();
            if (sclk_o != n[0] || !tgl_stb_o) mm++;
        end
        check("R3 continuous toggle mismatches", mm, 0);
        @(negedge clk);
        chan_en = 1'b0;
        @(negedge clk);

        // R4 field changes while enabled are ignored
        fine_sel = 1'b1; clkd_fld = 4'h3; ext_fld = 8'h00; cpol = 1'b0; cpha = 1'b0;
        @(negedge clk);
        chan_en = 1'b1;
        mask = 0;
        mm = 0;
        for (int n = 1; n <= 8; n++) begin
            step();
            if (tgl_stb_o) mask |= (1 << n);
            if (n == 4 && sclk_o != 1'b1) mm++;
            if (n == 8 && sclk_o != 1'b0) mm++;
            if (n == 2) begin
                @(negedge clk);
                fine_sel = 1'b0; clkd_fld = 4'h0; cpol = 1'b1; cpha = 1'b1;
            end
        end
        check("R4 transition positions", mask, (1 << 4) | (1 << 8));
        check("R4 levels unchanged", mm, 0);

        // R5 disable returns new idle level, no strobe
        @(negedge clk);
        chan_en = 1'b0;
        step();
        check("R5 sclk after disable", sclk_o, 1);
        check("R5 no strobe after disable", tgl_stb_o, 0);

        // R5 disable while at active level
        @(negedge clk);
        fine_sel = 1'b1; clkd_fld = 4'h7; ext_fld = 8'h00; cpol = 1'b1; cpha = 1'b0;
        @(negedge clk);
        chan_en = 1'b1;
        repeat (9) step();
        check("R5 active level reached", sclk_o, 0);
        @(negedge clk);
        chan_en = 1'b0;
        step();
        check("R5 idle within one cycle", sclk_o, 1);
        check("R7 no strobe on disable", tgl_stb_o, 0);

        // R6 restart from zero after a partial run
        @(negedge clk);
        fine_sel = 1'b1; clkd_fld = 4'h4; ext_fld = 8'h00; cpol = 1'b0; cpha = 1'b0;
        @(negedge clk);
        chan_en = 1'b1;
        repeat (7) step();
        measure(1'b1, 4'h4, 8'h00, 1'b0, 1'b0, 5, "R6 restart");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule